// File: doc/BRIEF.md
# Two-Wire Bus Target Front End

This block is the bus-facing half of a small serial memory target sitting on a two-wire open-drain bus. It oversamples the bus clock line and the bus data line with the fast system clock, recognises start and stop conditions, assembles bytes most significant bit first, and decides from the first byte of each transfer whether it is being addressed. When it is addressed, it pulls the data line low during the ninth bus clock to acknowledge. After that it either passes each received byte on to a memory-access controller or streams bytes from that controller back to the bus master.

The controller side is a plain strobe handshake. `sel_o` marks a matching address and carries the direction on `rd_dir_o`. `rx_valid_o` marks a written byte. `tx_take_o` marks the moment the block latched `tx_byte_i` for transmission, so the controller may advance its pointer. `stop_o` marks a stop condition. While `busy_i` is high the block is deaf: it answers no address, not even its own, which lets a master poll for the end of an internal write.

The FSM states are ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA, ST_WR_ACK, ST_RD_DATA, ST_RD_ACK and ST_IGNORE. These transitions are available from any state:

- A start goes to ST_ADDR, or to ST_IGNORE when busy.
- A stop goes to ST_IDLE.

All other transitions are taken on bus clock edges:

| From | Condition | To |
|---|---|---|
| ST_ADDR | eighth falling edge, address matches | ST_ADDR_ACK |
| ST_ADDR | eighth falling edge, no match | ST_IDLE |
| ST_ADDR_ACK | falling edge, write | ST_WR_DATA |
| ST_ADDR_ACK | falling edge, read | ST_RD_DATA |
| ST_WR_DATA | eighth falling edge | ST_WR_ACK |
| ST_WR_ACK | falling edge | ST_WR_DATA |
| ST_RD_DATA | eighth falling edge | ST_RD_ACK |
| ST_RD_ACK | falling edge, master acknowledged | ST_RD_DATA |
| ST_RD_ACK | falling edge, no acknowledge | ST_IGNORE |

Top module: `twowire_target`

## Requirements
- R1: A stop (data line rising while the clock line is high) returns the block to idle with the data line released, and pulses `stop_o` for one cycle when not busy.
- R2: The first byte after a start is compared as bits 7..4 = 1010, bits 3..1 = `strap_addr_i[2:0]`, and bit 0 = direction, with 1 meaning read. On a match the block pulls the data line low through the ninth bus clock and pulses `sel_o` with `rd_dir_o` equal to bit 0.
- R3: On an address mismatch the block gives no acknowledge, keeps the data line released and produces no `rx_valid_o` until the next start.
- R4: In write mode every following byte is presented on `rx_byte_o` with a one-cycle `rx_valid_o` and acknowledged during its ninth clock.
- R5: In read mode the block latches `tx_byte_i` at the falling bus clock edge that ends the acknowledge, pulses `tx_take_o`, and shifts the byte out most significant bit first.
- R6: After a read byte, a master acknowledge (data line low in the ninth clock) starts the next byte with another `tx_take_o`. A missing acknowledge leaves the data line released until the next start or stop.
- R7: A start seen while `busy_i` is high is ignored for the whole transfer: no acknowledge, no `sel_o`, even for the block's own address.
- R8: A repeated start in the middle of a transfer restarts address reception without a stop, so a write of one byte followed by a read works as one operation.
- R9: The block changes its data line drive only while the bus clock line is low.
- R10: After reset the data line is released and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_clk_i | input | 1 | Bus clock line as seen at the pad |
| line_dat_i | input | 1 | Bus data line as seen at the pad |
| dat_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| strap_addr_i | input | 3 | Pin-strapped low address bits |
| busy_i | input | 1 | Internal write in progress; the block answers nothing |
| sel_o | output | 1 | One-cycle pulse on a matching address |
| rd_dir_o | output | 1 | Direction of the current transfer, 1 = read |
| rx_valid_o | output | 1 | One-cycle pulse: a written byte is on `rx_byte_o` |
| rx_byte_o | output | 8 | Last byte received in write mode |
| tx_byte_i | input | 8 | Byte to transmit next in read mode |
| tx_take_o | output | 1 | One-cycle pulse: `tx_byte_i` was latched |
| stop_o | output | 1 | One-cycle pulse on a stop condition |

## Verification
Each edge on a bus line reaches the FSM after two synchroniser flops plus one edge-detect stage. The FSM's registered outputs, the data line drive and the strobes, therefore change three system clocks after the bus edge that causes them. The bench drives every bus phase for ten system clocks and samples the data line in the middle of the clock-high phase, well after any response has settled. The strobes are compared on the exact clock they appear, at the falling system clock edge, against a queue of expected bytes and an expected direction. A per-clock monitor flags any change of the drive while the bus clock line is high.

// File: rtl/twt_pkg.sv
package twt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } twt_state_t;
endpackage

// File: rtl/twt_sync.sv
module twt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/twt_events.sv
module twt_events (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_s,
    input  logic dat_s,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic clk_q, dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= 1'b1;
            dat_q <= 1'b1;
        end else begin
            clk_q <= clk_s;
            dat_q <= dat_s;
        end
    end

    assign rise_o  = clk_s & ~clk_q;
    assign fall_o  = ~clk_s & clk_q;
    assign start_o = clk_s & clk_q & dat_q & ~dat_s;
    assign stop_o  = clk_s & clk_q & ~dat_q & dat_s;
endmodule

// File: rtl/twowire_target.sv
module twowire_target
    import twt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PIN_BITS = 3,
    parameter int SYNC_STAGES = 2,
    parameter logic [BYTE_W-PIN_BITS-2:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk_i,
    input  logic              line_dat_i,
    output logic              dat_pull_o,
    input  logic [PIN_BITS-1:0] strap_addr_i,
    input  logic              busy_i,
    output logic              sel_o,
    output logic              rd_dir_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              tx_take_o,
    output logic              stop_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    // synchronise both bus lines
    logic [1:0] raw_lines, sync_lines;
    assign raw_lines = {line_clk_i, line_dat_i};

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : gen_sync
            twt_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_lines[gi]),
                .dout (sync_lines[gi])
            );
        end
    endgenerate

    logic clk_lvl, dat_lvl;
    assign clk_lvl = sync_lines[1];
    assign dat_lvl = sync_lines[0];

    logic clk_rise, clk_fall, start_det, stop_det;
    twt_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_s  (clk_lvl),
        .dat_s  (dat_lvl),
        .rise_o (clk_rise),
        .fall_o (clk_fall),
        .start_o(start_det),
        .stop_o (stop_det)
    );

    twt_state_t st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] shreg, shreg_n, rxb_n;
    logic pull_n, dir_n, mack, mack_n;
    logic rxv_n, sel_n, take_n, stop_n;

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        shreg_n = shreg;
        pull_n  = dat_pull_o;
        dir_n   = rd_dir_o;
        mack_n  = mack;
        rxb_n   = rx_byte_o;
        rxv_n   = 1'b0;
        sel_n   = 1'b0;
        take_n  = 1'b0;
        stop_n  = 1'b0;
        if (start_det) begin
            pull_n = 1'b0;
            cnt_n  = '0;
            st_n   = busy_i ? ST_IGNORE : ST_ADDR;
        end else if (stop_det) begin
            pull_n = 1'b0;
            stop_n = ~busy_i;
            st_n   = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE, ST_IGNORE: begin
                    pull_n = 1'b0;
                end
                ST_ADDR, ST_WR_DATA: begin
                    if (clk_rise) begin
                        shreg_n = {shreg[BYTE_W-2:0], dat_lvl};
                        cnt_n   = cnt + 1'b1;
                    end else if (clk_fall && cnt == LAST_BIT) begin
                        if (st == ST_WR_DATA) begin
                            pull_n = 1'b1;
                            rxv_n  = 1'b1;
                            rxb_n  = shreg;
                            st_n   = ST_WR_ACK;
                        end else if (shreg[BYTE_W-1:1] == {DEV_CODE, strap_addr_i}) begin
                            pull_n = 1'b1;
                            dir_n  = shreg[0];
                            sel_n  = 1'b1;
                            st_n   = ST_ADDR_ACK;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (clk_fall) begin
                        cnt_n = '0;
                        if (st == ST_ADDR_ACK && rd_dir_o) begin
                            shreg_n = tx_byte_i;
                            pull_n  = ~tx_byte_i[BYTE_W-1];
                            take_n  = 1'b1;
                            st_n    = ST_RD_DATA;
                        end else begin
                            pull_n = 1'b0;
                            st_n   = ST_WR_DATA;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (clk_rise) begin
                        cnt_n = cnt + 1'b1;
                    end else if (clk_fall) begin
                        if (cnt == LAST_BIT) begin
                            pull_n = 1'b0;
                            st_n   = ST_RD_ACK;
                        end else begin
                            pull_n  = ~shreg[BYTE_W-2];
                            shreg_n = {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (clk_rise) begin
                        mack_n = ~dat_lvl;
                    end else if (clk_fall) begin
                        cnt_n = '0;
                        if (mack) begin
                            shreg_n = tx_byte_i;
                            pull_n  = ~tx_byte_i[BYTE_W-1];
                            take_n  = 1'b1;
                            st_n    = ST_RD_DATA;
                        end else begin
                            pull_n = 1'b0;
                            st_n   = ST_IGNORE;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            shreg      <= '0;
            mack       <= 1'b0;
            dat_pull_o <= 1'b0;
            rd_dir_o   <= 1'b0;
            rx_byte_o  <= '0;
            rx_valid_o <= 1'b0;
            sel_o      <= 1'b0;
            tx_take_o  <= 1'b0;
            stop_o     <= 1'b0;
        end else begin
            cnt        <= cnt_n;
            shreg      <= shreg_n;
            mack       <= mack_n;
            dat_pull_o <= pull_n;
            rd_dir_o   <= dir_n;
            rx_byte_o  <= rxb_n;
            rx_valid_o <= rxv_n;
            sel_o      <= sel_n;
            tx_take_o  <= take_n;
            stop_o     <= stop_n;
        end
    end

    // assertions
    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !dat_pull_o));

    assert_rx_only_writing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !rd_dir_o);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid_o, tx_take_o, sel_o}));

    assert_silent_after_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !dat_pull_o);

    assert_deaf_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && busy_i) |=> (!dat_pull_o && st == ST_IGNORE));

    assert_drive_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_pull_o != $past(dat_pull_o)) |-> !$past(clk_lvl));
endmodule

// File: tb/twowire_target_tb.sv
module twowire_target_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_clk = 1'b1;
    logic m_dat = 1'b1;
    logic busy = 1'b0;
    logic [2:0] strap = 3'b101;
    logic dat_pull, sel, rd_dir, rx_valid, tx_take, stop_evt;
    logic [7:0] rx_byte, tx_byte;
    logic line_dat;

    int n_chk = 0, n_fail = 0;
    int hit_cnt = 0, take_cnt = 0, stop_cnt = 0, r9_viol = 0, ptr = 0;
    bit exp_dir = 1'b0;
    bit done = 1'b0;
    logic pull_prev = 1'b0;
    byte unsigned rxq[$];

    always #10 clk = ~clk;

    assign line_dat = m_dat & ~dat_pull;

    function automatic logic [7:0] memv(input int i);
        return 8'(8'h50 + i * 19);
    endfunction
    assign tx_byte = memv(ptr);

    twowire_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_clk_i  (m_clk),
        .line_dat_i  (line_dat),
        .dat_pull_o  (dat_pull),
        .strap_addr_i(strap),
        .busy_i      (busy),
        .sel_o       (sel),
        .rd_dir_o    (rd_dir),
        .rx_valid_o  (rx_valid),
        .rx_byte_o   (rx_byte),
        .tx_byte_i   (tx_byte),
        .tx_take_o   (tx_take),
        .stop_o      (stop_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (rxq.size() == 0) chk(1'b0, "R3 unexpected rx byte", int'(rx_byte), -1);
                else begin
                    automatic int e = int'(rxq.pop_front());
                    chk(int'(rx_byte) == e, "R4 rx byte", int'(rx_byte), e);
                end
            end
            if (sel) begin
                hit_cnt++;
                chk(rd_dir == exp_dir, "R2 direction", int'(rd_dir), int'(exp_dir));
            end
            if (tx_take) begin take_cnt++; ptr++; end
            if (stop_evt) stop_cnt++;
            if (dat_pull !== pull_prev && m_clk) r9_viol++;
            pull_prev = dat_pull;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_dat = 1'b1; wq(Q);
        m_clk = 1'b1; wq(Q);
        m_dat = 1'b0; wq(Q);
        m_clk = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_dat = 1'b0; wq(Q);
        m_clk = 1'b1; wq(Q);
        m_dat = 1'b1; wq(Q);
    endtask

    task automatic send(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_dat = b[i]; wq(Q);
            m_clk = 1'b1; wq(2 * Q);
            m_clk = 1'b0;
        end
        m_dat = 1'b1; wq(Q);
        m_clk = 1'b1; wq(Q);
        acked = ~line_dat; wq(Q);
        m_clk = 1'b0; wq(Q);
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] d);
        m_dat = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wq(Q);
            m_clk = 1'b1; wq(Q);
            d = {d[6:0], line_dat}; wq(Q);
            m_clk = 1'b0;
        end
        m_dat = ~give_ack; wq(Q);
        m_clk = 1'b1; wq(2 * Q);
        m_clk = 1'b0; wq(Q);
        m_dat = 1'b1;
    endtask

    initial begin
        bit ak;
        logic [7:0] d;
        int h0;
        wq(5);
        chk(dat_pull == 1'b0 && sel == 1'b0 && rx_valid == 1'b0, "R10 reset pull", int'(dat_pull), 0);
        chk(tx_take == 1'b0 && stop_evt == 1'b0, "R10 reset strobes", int'(tx_take), 0);
        rst_n = 1'b1;
        wq(5);

        // write of two bytes
        exp_dir = 1'b0;
        bus_start();
        send(8'b1010_101_0, ak); chk(ak, "R2 address ack", int'(ak), 1);
        rxq.push_back(8'h3C);
        send(8'h3C, ak); chk(ak, "R4 data ack", int'(ak), 1);
        rxq.push_back(8'hA5);
        send(8'hA5, ak); chk(ak, "R4 data ack", int'(ak), 1);
        bus_stop(); wq(Q);
        chk(rxq.size() == 0, "R4 bytes delivered", rxq.size(), 0);
        chk(stop_cnt == 1, "R1 stop strobe", stop_cnt, 1);
        chk(dat_pull == 1'b0, "R1 released after stop", int'(dat_pull), 0);

        // wrong device pins, then wrong type code
        h0 = hit_cnt;
        bus_start();
        send(8'b1010_011_0, ak); chk(!ak, "R3 wrong pins nack", int'(ak), 0);
        send(8'hFF, ak);         chk(!ak, "R3 data ignored", int'(ak), 0);
        bus_stop();
        bus_start();
        send(8'b1011_101_0, ak); chk(!ak, "R3 wrong type nack", int'(ak), 0);
        bus_stop(); wq(Q);
        chk(hit_cnt == h0, "R3 no select", hit_cnt, h0);

        // sequential read ending on a nack
        exp_dir = 1'b1;
        bus_start();
        send(8'b1010_101_1, ak); chk(ak, "R2 read address ack", int'(ak), 1);
        recv(1'b1, d); chk(d == memv(0), "R5 first read byte", int'(d), int'(memv(0)));
        recv(1'b1, d); chk(d == memv(1), "R6 next after ack", int'(d), int'(memv(1)));
        recv(1'b0, d); chk(d == memv(2), "R6 last byte", int'(d), int'(memv(2)));
        recv(1'b0, d); chk(d == 8'hFF, "R6 silent after nack", int'(d), 255);
        chk(take_cnt == 3, "R6 take count", take_cnt, 3);
        bus_stop();

        // one-byte write, repeated start, read
        h0 = hit_cnt;
        exp_dir = 1'b0;
        bus_start();
        send(8'b1010_101_0, ak); chk(ak, "R8 write address ack", int'(ak), 1);
        rxq.push_back(8'h07);
        send(8'h07, ak); chk(ak, "R8 pointer byte ack", int'(ak), 1);
        exp_dir = 1'b1;
        bus_start();
        send(8'b1010_101_1, ak); chk(ak, "R8 repeated start ack", int'(ak), 1);
        recv(1'b0, d); chk(d == memv(3), "R8 read after restart", int'(d), int'(memv(3)));
        bus_stop(); wq(Q);
        chk(hit_cnt == h0 + 2, "R8 two selects", hit_cnt, h0 + 2);

        // busy polling
        h0 = hit_cnt;
        busy = 1'b1;
        exp_dir = 1'b0;
        bus_start();
        send(8'b1010_101_0, ak); chk(!ak, "R7 busy write poll", int'(ak), 0);
        bus_stop();
        bus_start();
        send(8'b1010_101_1, ak); chk(!ak, "R7 busy read poll", int'(ak), 0);
        bus_stop(); wq(Q);
        chk(hit_cnt == h0, "R7 no select while busy", hit_cnt, h0);
        busy = 1'b0;
        bus_start();
        send(8'b1010_101_0, ak); chk(ak, "R7 ack once idle", int'(ak), 1);
        bus_stop(); wq(Q);

        chk(r9_viol == 0, "R9 drive stable while clock high", r9_viol, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule